// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a single-port synchronous static memory that uses a pipelined read and a late-write protocol. Every command is taken on the rising clock edge. A read registers its address, looks up the storage during the following cycle and loads the result into an output register. The read data is therefore on the bus for the whole cycle after the next edge. A write takes its address and lane mask on one edge and its data on the next edge. The storage itself is not updated until another write address arrives. Until then the pending write sits in a one-entry buffer, and any read of that address gets the newest bytes from the buffer.

The data word is split into equal lanes, four lanes of 9 bits by default. Each lane has its own active-low write enable. The bus is modelled as a data output with a separate drive-enable. An undriven bus reads as zero. An output enable and a sleep input act on the drive-enable without waiting for a clock. While the write data is on the bus, a turnaround flag is raised and the read driver is held off. The depth is set by an address-width parameter, so it can be kept small for simulation.

Top module: `lwsram_core`

## Requirements
- R1: With `sleep` low, `sel_n` low and `wr_n` high at edge k (a read), `q` holds the word at `addr` and `q_en` is high during the cycle after edge k+1. This holds provided `oe_n` and `sleep` are low and no write data cycle falls in that slot.
- R2: With `sleep` low, `sel_n` low and `wr_n` low at edge k (a write), `din` is taken at edge k+1. Bit i of `lane_wr_n`, when low, allows bits [9i+8:9i] to be updated. Lanes whose bit is high keep their old contents.
- R3: A read returns the newest data for its address, including a write whose data was taken on the same edge as the read address. The written lanes come from the pending write and the other lanes keep the stored value.
- R4: Back-to-back writes to any addresses are all kept. Each pending write is placed in storage when the next write address is accepted.
- R5: A cycle with `sel_n` high is a deselect. `q_en` is low in the output slot that belongs to that cycle.
- R6: `oe_n` high forces `q_en` low without waiting for a clock edge.
- R7: With `sleep` high, the command inputs are ignored, so no read or write is started, and `q_en` is low without waiting for a clock edge. Stored contents are kept.
- R8: `bus_turn` is high exactly in the cycle after a write is accepted, which is the write data cycle. `q_en` is low whenever `bus_turn` is high, so a read issued on the edge just before a write loses its output slot.
- R9: After a synchronous reset, with `rst_n` low at a clock edge, `q_en` and `bus_turn` are low and no write is pending.
- R10: `q` is all zeros whenever `q_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| sleep | input | 1 | Idle request: ignores commands and disables the driver |
| sel_n | input | 1 | Select, active low; high means a deselect cycle |
| wr_n | input | 1 | Write enable, active low; high with select low means read |
| lane_wr_n | input | LANES | Per-lane write enables, active low, bit i for lane i |
| addr | input | AW | Word address, taken with the command |
| oe_n | input | 1 | Output enable, active low, not clocked |
| din | input | LANES*LANE_W | Write data, taken one edge after its address |
| q | output | LANES*LANE_W | Read data, zero when not driven |
| q_en | output | 1 | Bus drive enable (low means high impedance) |
| bus_turn | output | 1 | High during a write data cycle |

## Verification
Two things can meet in one cycle: the write data cycle and the output slot of the read issued just before that write. The bench gives both orders of read and write, close together and on the same few addresses. It then checks that the read slot is dropped, with `q_en` low and `q` zero, while `bus_turn` is high. A second meeting is a pending write and a read of the same address. This is provoked by reading an address on the very edge that takes the partial-lane data of a write to it. The bench expects a lane-by-lane blend of new and stored bytes, computed from its own model, which applies each write at its data edge.

// File: rtl/lwsram_pkg.sv
// Package: shared constants and the command type of the late-write SRAM.
// Assumes the default lane layout of four lanes of nine bits each.
package lwsram_pkg;
    localparam int DEF_LANES  = 4;
    localparam int DEF_LANE_W = 9;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } lw_cmd_e;
endpackage

// File: rtl/lwsram_lane_mem.sv
// Module: storage for one byte lane. It has one synchronous write port and one
// combinational read port. Assumes the read address is already registered by
// the caller, so the read finishes inside the cycle after the address edge.
module lwsram_lane_mem #(
    parameter int AW     = 6,
    parameter int LANE_W = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [LANE_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [LANE_W-1:0] mem [DEPTH];

    // Write the committed lane on the clock edge.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Look up the registered read address.
    assign rdata = mem[raddr];
endmodule

// File: rtl/lwsram_wbuf.sv
// Module: late-write stage, one-entry posted buffer and read bypass merge.
// A write address and mask are staged on acceptance. The data joins them on
// the following edge. The newest entry is committed to storage when the next
// write address is accepted, and on a back-to-back write that newest entry is
// the one arriving on that same edge. Assumes the caller handles sleep and
// select in wr_acc.
module lwsram_wbuf #(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_acc,
    input  logic [AW-1:0]           addr,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic [LANES*LANE_W-1:0] din,
    input  logic [AW-1:0]           raddr_q,
    input  logic [LANES*LANE_W-1:0] arr_word,
    output logic [LANES-1:0]        cmt_en,
    output logic [AW-1:0]           cmt_addr,
    output logic [LANES*LANE_W-1:0] cmt_data,
    output logic                    data_phase,
    output logic [LANES*LANE_W-1:0] merged
);
    localparam int DW = LANES * LANE_W;

    logic [AW-1:0]    stg_addr;
    logic [LANES-1:0] stg_mask;
    logic             buf_vld;
    logic [AW-1:0]    buf_addr;
    logic [LANES-1:0] buf_mask;
    logic [DW-1:0]    buf_data;

    logic             cur_vld;
    logic [LANES-1:0] cur_mask;
    logic             hit;

    // Select the newest entry: the incoming data when in a data cycle, else the buffer.
    always_comb begin
        cur_vld  = data_phase | buf_vld;
        cur_mask = data_phase ? stg_mask : buf_mask;
        cmt_addr = data_phase ? stg_addr : buf_addr;
        cmt_data = data_phase ? din      : buf_data;
    end

    // Stage the write address and mask, then fill the buffer when the data arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_phase <= 1'b0;
            stg_addr   <= '0;
            stg_mask   <= '0;
            buf_vld    <= 1'b0;
            buf_addr   <= '0;
            buf_mask   <= '0;
            buf_data   <= '0;
        end else begin
            data_phase <= wr_acc;
            if (wr_acc) begin
                stg_addr <= addr;
                stg_mask <= ~lane_wr_n;
            end
            if (data_phase) begin
                buf_vld  <= 1'b1;
                buf_addr <= stg_addr;
                buf_mask <= stg_mask;
                buf_data <= din;
            end
        end
    end

    // The buffered entry matches the registered read address.
    assign hit = buf_vld && (buf_addr == raddr_q);

    // Per lane: commit on a new write address, and blend the buffer into reads.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign cmt_en[i] = wr_acc & cur_vld & cur_mask[i];
        assign merged[i*LANE_W +: LANE_W] = (hit && buf_mask[i])
                                          ? buf_data[i*LANE_W +: LANE_W]
                                          : arr_word[i*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/lwsram_core.sv
// Module: top of the late-write pipelined synchronous SRAM.
// It decodes the command, runs the registered read pipe and drives the bus.
// Assumes a single command per cycle. The bus is modelled as data plus a
// drive-enable, and an undriven bus reads as zero.
module lwsram_core #(
    parameter int AW     = 6,
    parameter int LANES  = lwsram_pkg::DEF_LANES,
    parameter int LANE_W = lwsram_pkg::DEF_LANE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sleep,
    input  logic                    sel_n,
    input  logic                    wr_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic [AW-1:0]           addr,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] q,
    output logic                    q_en,
    output logic                    bus_turn
);
    import lwsram_pkg::*;

    localparam int DW = LANES * LANE_W;

    lw_cmd_e          cmd;
    logic             wr_acc;
    logic             rd_pend;
    logic [AW-1:0]    raddr_q;
    logic             out_vld;
    logic [DW-1:0]    out_data;
    logic [DW-1:0]    arr_word;
    logic [DW-1:0]    merged;
    logic [LANES-1:0] cmt_en;
    logic [AW-1:0]    cmt_addr;
    logic [DW-1:0]    cmt_data;
    logic             data_phase;

    // Decode the sampled command; sleep or a high select gives no command.
    always_comb begin
        if (sleep || sel_n) begin
            cmd = CMD_NOP;
        end else if (wr_n) begin
            cmd = CMD_READ;
        end else begin
            cmd = CMD_WRITE;
        end
    end

    assign wr_acc = (cmd == CMD_WRITE);

    // Register the read address, then load the output register one edge later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend  <= 1'b0;
            raddr_q  <= '0;
            out_vld  <= 1'b0;
            out_data <= '0;
        end else begin
            rd_pend <= (cmd == CMD_READ);
            if (cmd == CMD_READ) begin
                raddr_q <= addr;
            end
            out_vld  <= rd_pend;
            out_data <= merged;
        end
    end

    // One storage slice per lane so that each lane commits on its own.
    for (genvar i = 0; i < LANES; i++) begin : g_mem
        lwsram_lane_mem #(
            .AW     (AW),
            .LANE_W (LANE_W)
        ) i_lane (
            .clk   (clk),
            .we    (cmt_en[i]),
            .waddr (cmt_addr),
            .wdata (cmt_data[i*LANE_W +: LANE_W]),
            .raddr (raddr_q),
            .rdata (arr_word[i*LANE_W +: LANE_W])
        );
    end

    lwsram_wbuf #(
        .AW     (AW),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) i_wbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_acc     (wr_acc),
        .addr       (addr),
        .lane_wr_n  (lane_wr_n),
        .din        (din),
        .raddr_q    (raddr_q),
        .arr_word   (arr_word),
        .cmt_en     (cmt_en),
        .cmt_addr   (cmt_addr),
        .cmt_data   (cmt_data),
        .data_phase (data_phase),
        .merged     (merged)
    );

    // Drive the bus only in a read slot with no write data, output enable low and no sleep.
    always_comb begin
        q_en     = out_vld & ~data_phase & ~oe_n & ~sleep;
        q        = q_en ? out_data : '0;
        bus_turn = data_phase;
    end
endmodule

// File: rtl/lwsram_chk.sv
// Module: protocol checker for lwsram_core, attached by bind.
// Assumes only the top-level ports are visible.
module lwsram_chk #(
    parameter int DW = 36
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sleep,
    input logic          sel_n,
    input logic          wr_n,
    input logic          oe_n,
    input logic [DW-1:0] q,
    input logic          q_en,
    input logic          bus_turn
);
    // R5
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n && !sleep) |=> ##1 !q_en);

    // R6
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !q_en);

    // R7
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !q_en);

    // R8
    turn_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !sel_n && !wr_n) |=> bus_turn);

    // R8
    turn_blocks_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_turn |-> !q_en);

    // R9
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!q_en && !bus_turn));

    // R10
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q_en |-> (q == '0));
endmodule

bind lwsram_core lwsram_chk #(.DW(LANES*LANE_W)) i_lwsram_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep    (sleep),
    .sel_n    (sel_n),
    .wr_n     (wr_n),
    .oe_n     (oe_n),
    .q        (q),
    .q_en     (q_en),
    .bus_turn (bus_turn)
);

// File: tb/test_lwsram_core.sv
// Bench: directed corner cases, then seeded random commands. Each output is
// compared with a bench model that applies every write at its data edge.
module test_lwsram_core;
    localparam int AW    = 6;
    localparam int LANES = 4;
    localparam int LW    = 9;
    localparam int DW    = LANES * LW;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n;
    logic             sleep;
    logic             sel_n;
    logic             wr_n;
    logic [LANES-1:0] lane_wr_n;
    logic [AW-1:0]    addr;
    logic             oe_n;
    logic [DW-1:0]    din;
    logic [DW-1:0]    q;
    logic             q_en;
    logic             bus_turn;

    lwsram_core #(.AW(AW), .LANES(LANES), .LANE_W(LW)) i_lwsram_core (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .sel_n(sel_n), .wr_n(wr_n),
        .lane_wr_n(lane_wr_n), .addr(addr), .oe_n(oe_n), .din(din),
        .q(q), .q_en(q_en), .bus_turn(bus_turn)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [DW-1:0]    ref_mem [DEPTH];
    logic             m_rdpend, m_outvld, m_dph;
    logic [DW-1:0]    m_rdval, m_outdata;
    logic [AW-1:0]    m_paddr;
    logic [LANES-1:0] m_pmask;

    function automatic logic [DW-1:0] pat(input int a, input int salt);
        return {4'h0, 32'(a * 32'h9E37_79B1 + salt * 32'h0101_0101 + 32'h1357)};
    endfunction

    function automatic logic exp_drive();
        return m_outvld & ~m_dph & ~oe_n & ~sleep;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare the outputs that follow the last edge with the model.
    task automatic check_outputs();
        logic en;
        en = exp_drive();
        chk(bus_turn == m_dph, "R8 bus_turn", DW'(bus_turn), DW'(m_dph));
        chk(q_en == en, "R1 R5 R6 R7 R8 q_en", DW'(q_en), DW'(en));
        if (en) begin
            chk(q == m_outdata, "R1 R2 R3 R4 R7 read data", q, m_outdata);
        end else begin
            chk(q == '0, "R10 undriven bus", q, '0);
        end
    endtask

    // One cycle: check, drive the next inputs, advance the model by one edge.
    task automatic step(input bit s_sleep, input bit s_sel_n, input bit s_wr_n,
                        input logic [LANES-1:0] s_lanes, input int s_addr,
                        input bit s_oe_n, input logic [DW-1:0] s_din);
        logic nv;
        logic [DW-1:0] nd;
        @(negedge clk);
        check_outputs();
        sleep = s_sleep; sel_n = s_sel_n; wr_n = s_wr_n; lane_wr_n = s_lanes;
        addr = AW'(s_addr); oe_n = s_oe_n; din = s_din;
        nv = m_rdpend;
        nd = m_rdval;
        if (m_dph) begin
            for (int i = 0; i < LANES; i++) begin
                if (m_pmask[i]) ref_mem[m_paddr][i*LW +: LW] = s_din[i*LW +: LW];
            end
        end
        m_rdpend = !s_sleep && !s_sel_n && s_wr_n;
        if (m_rdpend) m_rdval = ref_mem[AW'(s_addr)];
        m_dph = !s_sleep && !s_sel_n && !s_wr_n;
        if (m_dph) begin
            m_paddr = AW'(s_addr);
            m_pmask = ~s_lanes;
        end
        m_outvld  = nv;
        m_outdata = nd;
    endtask

    task automatic nop(input logic [DW-1:0] d);
        step(1'b0, 1'b1, 1'b1, '1, 0, 1'b0, d);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24681357));
        rst_n = 1'b0; sleep = 1'b0; sel_n = 1'b1; wr_n = 1'b1; lane_wr_n = '1;
        addr = '0; oe_n = 1'b0; din = '0;
        m_rdpend = 0; m_outvld = 0; m_dph = 0; m_rdval = '0; m_outdata = '0;
        m_paddr = '0; m_pmask = '0;
        repeat (3) @(negedge clk);
        // R9: after reset, no drive and no turnaround
        chk(q_en == 1'b0, "R9 q_en after reset", DW'(q_en), '0);
        chk(bus_turn == 1'b0, "R9 bus_turn after reset", DW'(bus_turn), '0);
        rst_n = 1'b1;

        // R4: fill every word with back-to-back full writes
        for (int a = 0; a < DEPTH; a++) begin
            step(1'b0, 1'b0, 1'b0, 4'b0000, a, 1'b0, (a == 0) ? '0 : pat(a - 1, 0));
        end
        nop(pat(DEPTH - 1, 0));
        for (int a = 0; a < DEPTH; a++) step(1'b0, 1'b0, 1'b1, '1, a, 1'b0, '0);
        nop('0); nop('0);

        // R3: read on the edge that takes the write data (full bypass)
        step(1'b0, 1'b0, 1'b0, 4'b0000, 3, 1'b0, '0);
        step(1'b0, 1'b0, 1'b1, '1, 3, 1'b0, pat(3, 7));
        nop('0); nop('0);
        // R2 R3: partial lanes 0 and 2, read merges with stored lanes 1 and 3
        step(1'b0, 1'b0, 1'b0, 4'b1010, 3, 1'b0, '0);
        step(1'b0, 1'b0, 1'b1, '1, 3, 1'b0, pat(9, 9));
        nop('0); nop('0);
        // R8: read then write at once, the read slot is dropped
        step(1'b0, 1'b0, 1'b1, '1, 7, 1'b0, '0);
        step(1'b0, 1'b0, 1'b0, 4'b0110, 8, 1'b0, '0);
        nop(pat(8, 5)); nop('0);
        // R6: output enable high during a read slot
        step(1'b0, 1'b0, 1'b1, '1, 8, 1'b0, '0);
        step(1'b0, 1'b1, 1'b1, '1, 0, 1'b1, '0);
        nop('0);
        // R7: write under sleep is ignored, then read back the old word
        step(1'b1, 1'b0, 1'b0, 4'b0000, 5, 1'b0, '0);
        step(1'b1, 1'b0, 1'b1, '1, 5, 1'b0, pat(5, 99));
        step(1'b0, 1'b0, 1'b1, '1, 5, 1'b0, '0);
        nop('0); nop('0);
        // R5: deselect between reads
        step(1'b0, 1'b0, 1'b1, '1, 1, 1'b0, '0);
        nop('0);
        step(1'b0, 1'b0, 1'b1, '1, 2, 1'b0, '0);
        nop('0); nop('0);

        // Random mix on a narrow address range to force hits and collisions.
        for (int n = 0; n < 4000; n++) begin
            int unsigned r;
            bit s_sl, s_se, s_wr, s_oe;
            r    = $urandom;
            s_sl = (r[3:0] == 4'd0);
            s_se = (r[6:4] == 3'd0);
            s_wr = r[7];
            s_oe = (r[10:8] == 3'd0);
            step(s_sl, s_se, s_wr, 4'($urandom), int'($urandom % 8), s_oe,
                 {4'($urandom), 32'($urandom)});
        end
        nop('0); nop('0); nop('0);
        @(negedge clk);
        check_outputs();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule